// File: doc/BRIEF.md
# Weight-Stationary Multiply-Accumulate Grid

This block is a rectangular grid of multiply-accumulate cells for convolution and matrix-product inner loops. Every cell keeps one signed filter weight in its own register. The weight stays put while a stream of activation vectors passes through the grid. Each column stands for one output channel and each row for one input channel of the current tile. A row's activation reaches every cell of that row in the same cycle. The running sum of a column moves down one row per cycle and picks up one product at each row. The finished column totals appear at the bottom edge.

The block has two modes. While `wt_load` is high, weights enter at the top row and shift down the columns one row per cycle, so filling a grid of ROWS rows takes ROWS cycles. While `wt_load` is low, the block computes and accepts a new activation vector on every cycle in which `act_valid` is high. The activation of row r is delayed by r cycles inside the block, which lines it up with the running sum arriving at that row. A cycle with `act_valid` low leaves a bubble that travels down the grid without disturbing any sum.

Top module: `ws_mac_grid`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first result arrives, `out_valid` is all zeros and every `out_sum` lane is zero. All stored weights are reset to zero.
- R2: On each cycle with `wt_load` high, row 0 of column c captures `wt_in[c*8 +: 8]` and every other row takes the weight of the row above it. After ROWS consecutive load cycles, the value presented on load cycle m (counted from 0) sits in row ROWS-1-m.
- R3: An `act_valid` pulse in a cycle where `wt_load` is also high is dropped. It never produces an `out_valid` pulse, and no accumulation is started.
- R4: For an accepted vector, lane c of `out_sum` (bits `c*32 +: 32`) equals the sum over rows r of weight[r][c] × `act_in[r*8 +: 8]`. Both factors are 8-bit two's complement, and the sum is a 32-bit two's complement value that starts from zero at the top row.
- R5: A vector accepted in the cycle before clock edge k produces its `out_valid` and `out_sum` in the cycle after edge k+ROWS-1, that is ROWS cycles after it was presented.
- R6: Vectors presented on consecutive cycles give results on consecutive cycles, each with its own correct sum, with no stall.
- R7: A cycle with `act_valid` low yields no `out_valid` pulse ROWS cycles later and does not change the sums of its neighbours. While `out_valid` is low, `out_sum` holds its last value.
- R8: While `wt_load` is low, the stored weights do not change, so every vector of a tile is multiplied by the same weights.
- R9: All bits of `out_valid` rise and fall together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wt_load | input | 1 | High selects weight-load mode; low selects compute mode |
| wt_in | input | COLS*8 | One signed weight per column, entering the top row |
| act_valid | input | 1 | Activation vector on `act_in` is present |
| act_in | input | ROWS*8 | One signed activation per row, row r at bits r*8 |
| out_valid | output | COLS | Per-column result strobe |
| out_sum | output | COLS*32 | Per-column signed 32-bit result, column c at bits c*32 |

## Verification
Two functions can fall in the same cycle: loading weights and presenting an activation vector. The bench provokes this by raising `act_valid` on every cycle of a full weight reload. It then judges that no result strobe appears ROWS cycles later and that the next tile uses exactly the newly shifted weights. A second overlap comes from bubbles mixed into a back-to-back stream. In that case the grid must drop a strobe in the right cycle, keep the bottom-edge value frozen during it, and still produce exact sums for the neighbouring vectors. A behavioural model predicts the expected strobe and sums for every cycle and compares them on every clock.

// File: rtl/ws_mac_grid.sv
module ws_mac_grid #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int AW   = 8,
  parameter int PW   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wt_load,
  input  logic [COLS*AW-1:0]   wt_in,
  input  logic                 act_valid,
  input  logic [ROWS*AW-1:0]   act_in,
  output logic [COLS-1:0]      out_valid,
  output logic [COLS*PW-1:0]   out_sum
);

  logic signed [AW-1:0] wq   [ROWS][COLS];
  logic signed [PW-1:0] ps   [ROWS][COLS];
  logic signed [AW-1:0] arow [ROWS];
  logic [ROWS-1:0]      vin;
  logic [ROWS-1:0]      vld_q;
  logic [ROWS*COLS*AW-1:0] wt_flat;

  assign vin[0] = act_valid & ~wt_load;

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vin;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    if (r == 0) begin : g_top
      assign arow[0] = act_in[0 +: AW];
    end else begin : g_skew
      logic signed [AW-1:0] dl [r];
      assign vin[r]  = vld_q[r-1];
      assign arow[r] = dl[r-1];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int k = 0; k < r; k++) dl[k] <= '0;
        end else begin
          dl[0] <= act_in[r*AW +: AW];
          for (int k = 1; k < r; k++) dl[k] <= dl[k-1];
        end
      end
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic signed [PW-1:0] above;
      logic signed [PW-1:0] prod;

      if (r == 0) begin : g_w0
        assign above = '0;
        always_ff @(posedge clk) begin
          if (!rst_n)       wq[0][c] <= '0;
          else if (wt_load) wq[0][c] <= wt_in[c*AW +: AW];
        end
      end else begin : g_wn
        assign above = ps[r-1][c];
        always_ff @(posedge clk) begin
          if (!rst_n)       wq[r][c] <= '0;
          else if (wt_load) wq[r][c] <= wq[r-1][c];
        end
      end

      assign prod = PW'(wq[r][c]) * PW'(arow[r]);

      always_ff @(posedge clk) begin
        if (!rst_n)      ps[r][c] <= '0;
        else if (vin[r]) ps[r][c] <= above + prod;
      end

      assign wt_flat[(r*COLS+c)*AW +: AW] = wq[r][c];
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_out
    assign out_sum[c*PW +: PW] = ps[ROWS-1][c];
  end

  assign out_valid = {COLS{vld_q[ROWS-1]}};

endmodule

// File: rtl/ws_mac_grid_chk.sv
module ws_mac_grid_chk #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int AW   = 8,
  parameter int PW   = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wt_load,
  input logic [COLS*AW-1:0]        wt_in,
  input logic [COLS-1:0]           out_valid,
  input logic [COLS*PW-1:0]        out_sum,
  input logic                      row0_vld,
  input logic [ROWS*COLS*AW-1:0]   wt_flat
);

  p_top_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wt_load |=> wt_flat[COLS*AW-1:0] == $past(wt_in));

  if (ROWS > 1) begin : g_shift
    p_row_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wt_load |=> wt_flat[ROWS*COLS*AW-1:COLS*AW] == $past(wt_flat[(ROWS-1)*COLS*AW-1:0]));
  end

  p_load_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wt_load |=> !row0_vld);

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == '0) |-> $stable(out_sum));

  p_weight_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wt_load |=> $stable(wt_flat));

endmodule

bind ws_mac_grid ws_mac_grid_chk #(.ROWS(ROWS), .COLS(COLS), .AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wt_load(wt_load), .wt_in(wt_in),
  .out_valid(out_valid), .out_sum(out_sum), .row0_vld(vld_q[0]), .wt_flat(wt_flat)
);

// File: tb/ws_mac_grid_tb_top.sv
`timescale 1ns/1ps
module ws_mac_grid_tb_top;
  localparam int N  = 4;
  localparam int M  = 4;
  localparam int AW = 8;
  localparam int PW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wt_load = 1'b0;
  logic act_valid = 1'b0;
  logic [M*AW-1:0] wt_in = '0;
  logic [N*AW-1:0] act_in = '0;
  logic [M-1:0]    out_valid;
  logic [M*PW-1:0] out_sum;

  always #2 clk = ~clk;

  ws_mac_grid #(.ROWS(N), .COLS(M), .AW(AW), .PW(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wt_load(wt_load), .wt_in(wt_in),
    .act_valid(act_valid), .act_in(act_in),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  int    w_m [N][M];
  int    last_sum [M];
  int    q_due [$];
  int    q_sum [$];
  string q_tag [$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    active = 0;
  bit    done = 0;
  string cur_tag = "R4";
  string idle_tag = "R7";

  task automatic chk(string tag, string what, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: got %0d expected %0d", tag, what, cyc, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) for (int j = 0; j < M; j++) w_m[i][j] = 0;
      for (int j = 0; j < M; j++) last_sum[j] = 0;
      q_due.delete(); q_sum.delete(); q_tag.delete();
    end else begin
      if (act_valid && !wt_load) begin
        q_due.push_back(cyc + N - 1);
        q_tag.push_back(cur_tag);
        for (int j = 0; j < M; j++) begin
          int s;
          s = 0;
          for (int i = 0; i < N; i++) begin
            int a;
            a = $signed(act_in[i*AW +: AW]);
            s = s + w_m[i][j] * a;
          end
          q_sum.push_back(s);
        end
      end
      if (wt_load) begin
        for (int i = N-1; i > 0; i--) for (int j = 0; j < M; j++) w_m[i][j] = w_m[i-1][j];
        for (int j = 0; j < M; j++) w_m[0][j] = $signed(wt_in[j*AW +: AW]);
      end
    end
  end

  always @(negedge clk) begin
    if (active) begin
      if (q_due.size() > 0 && q_due[0] == cyc) begin
        string t;
        t = q_tag.pop_front();
        void'(q_due.pop_front());
        chk({t, "/R5/R9"}, "out_valid", out_valid, {M{1'b1}});
        for (int j = 0; j < M; j++) begin
          int e;
          e = q_sum.pop_front();
          chk(t, $sformatf("out_sum[%0d]", j), $signed(out_sum[j*PW +: PW]), e);
          last_sum[j] = e;
        end
      end else begin
        chk({idle_tag, "/R9"}, "out_valid idle", out_valid, 0);
        for (int j = 0; j < M; j++)
          chk("R7", $sformatf("out_sum[%0d] hold", j), $signed(out_sum[j*PW +: PW]), last_sum[j]);
      end
    end
  end

  task automatic step(bit v, bit ld, logic [N*AW-1:0] a, logic [M*AW-1:0] w);
    act_valid = v; wt_load = ld; act_in = a; wt_in = w;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, '0, '0);
  endtask

  function automatic logic [N*AW-1:0] rvec_a();
    logic [N*AW-1:0] v;
    for (int i = 0; i < N; i++) v[i*AW +: AW] = AW'($urandom);
    return v;
  endfunction

  function automatic logic [M*AW-1:0] rvec_w();
    logic [M*AW-1:0] v;
    for (int j = 0; j < M; j++) v[j*AW +: AW] = AW'($urandom);
    return v;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, got hung expected finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R1", "out_valid in reset", out_valid, 0);
    chk("R1", "out_sum in reset", out_sum, 0);
    rst_n = 1'b1;
    active = 1;
    idle(2);

    // R1: zero weights give zero sums
    cur_tag = "R1";
    step(1, 0, rvec_a(), '0);
    idle(N + 1);

    // R2: load distinct weights, then read them back with one-hot rows
    for (int k = 0; k < N; k++) begin
      logic [M*AW-1:0] w;
      for (int j = 0; j < M; j++) w[j*AW +: AW] = AW'(k*16 + j*3 - 20);
      step(0, 1, '0, w);
    end
    cur_tag = "R2";
    for (int i = 0; i < N; i++) begin
      logic [N*AW-1:0] a;
      a = '0;
      a[i*AW +: AW] = 8'sd1;
      step(1, 0, a, '0);
    end
    idle(N + 1);

    // R5: an isolated vector
    cur_tag = "R5";
    step(1, 0, rvec_a(), '0);
    idle(N + 2);

    // R6: back-to-back stream with fresh weights
    for (int k = 0; k < N; k++) step(0, 1, '0, rvec_w());
    cur_tag = "R6";
    for (int k = 0; k < 12; k++) step(1, 0, rvec_a(), '0);
    idle(N + 1);

    // R7: bubbles mixed into the stream
    cur_tag = "R7";
    for (int k = 0; k < 15; k++) step((k % 3) != 1, 0, rvec_a(), '0);
    for (int k = 0; k < 8; k++) step(k[0], 0, rvec_a(), '0);
    idle(N + 1);

    // R3: activation offered on every load cycle
    idle_tag = "R3";
    for (int k = 0; k < N; k++) step(1, 1, rvec_a(), rvec_w());
    idle(N + 1);
    idle_tag = "R7";
    cur_tag = "R3";
    for (int k = 0; k < 4; k++) step(1, 0, rvec_a(), '0);
    idle(N + 1);

    // R4: extreme operands
    for (int k = 0; k < N; k++) step(0, 1, '0, {M{8'h80}});
    cur_tag = "R4";
    step(1, 0, {N{8'h80}}, '0);
    step(1, 0, {N{8'h7f}}, '0);
    step(1, 0, {8'h7f, 8'h80, 8'h7f, 8'h80}, '0);
    step(1, 0, '0, '0);
    idle(N + 1);

    // R8: long tile on the same weights
    for (int k = 0; k < N; k++) step(0, 1, '0, rvec_w());
    cur_tag = "R8";
    for (int k = 0; k < 24; k++) step(1, 0, rvec_a(), rvec_w());
    idle(N + 2);

    finish_run();
  end
endmodule